// File: doc/BRIEF.md
# Prefixed Bit Manipulation Unit

This unit executes the opcode byte that follows the bit-operation prefix. It splits the byte into an operation group, a sub-operation or bit index, and an operand selector. It then performs one of eight rotate/shift/swap operations, a single-bit test, a single-bit clear or a single-bit set. The caller supplies the current flags, the value of the selected register and the HL pointer with each request. The unit returns the new byte, the new flags, and an indication of whether a register must be written back.

One clock of this unit is one machine cycle, which is four ticks. A request is accepted on a `req_valid`/`req_ready` handshake.

- **Back-pressure:** `req_ready` is high only while the unit is idle. A caller that sees it low must hold the opcode and all operands stable until the handshake completes.
- **Register operand:** `done` pulses one cycle after acceptance.
- **Memory operand:** the unit reads the byte at HL in the cycle after acceptance. For every group except bit test, it writes the modified byte back in the next cycle. `done` pulses in the cycle after the last memory access. Each request therefore costs one machine cycle more than the shorter form before it.

Top module: `bitop_unit`

## Requirements
- R1: Opcode bits 7:6 select the group: 00 rotate/shift/swap, 01 bit test, 10 bit clear, 11 bit set. Bits 5:3 are the sub-operation or bit index. Bits 2:0 select the operand: 0..5 are registers B,C,D,E,H,L, 6 is the memory byte at HL, and 7 is A. `res_reg_sel` returns bits 2:0 of the accepted opcode when `done` is high.
- R2: In group 00, sub-operations 0..3 are rotate left circular, rotate right circular, rotate left through carry and rotate right through carry. The new carry is the bit that left the byte.
- R3: In group 00, sub-operation 4 shifts left with 0 into bit 0. Sub-operation 5 shifts right and keeps bit 7. Sub-operation 7 shifts right with 0 into bit 7. In each case the new carry is the bit shifted out.
- R4: Flags are packed as {Z,N,H,C} in bits 3:0. For all group 00 operations, Z is set when the result is zero and N and H are cleared. Sub-operation 6 exchanges the nibbles and clears C.
- R5: Bit test sets Z when the selected bit is 0, clears N, sets H, keeps C, returns the operand unchanged and asserts no register write.
- R6: Bit clear and bit set change only the selected bit and return the input flags unchanged.
- R7: A register-operand request raises `done` one cycle after acceptance. It produces no memory strobe, and `res_wr_reg` is 1 except for bit test.
- R8: A memory-operand request that is not a bit test asserts `mem_rd` at address HL in cycle 1 and `mem_wr` with the result at HL in cycle 2. `done` follows in cycle 3 with `res_wr_reg` 0. The value of `req_operand` is ignored.
- R9: A memory-operand bit test asserts `mem_rd` in cycle 1, never asserts `mem_wr`, and raises `done` in cycle 2.
- R10: `req_ready` is low from acceptance until the cycle after `done`. A request presented meanwhile is not taken and does not disturb the operation in flight. `done` lasts one cycle.
- R11: After reset, `req_ready` is 1 and `done`, `mem_rd` and `mem_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_opcode | input | 8 | Prefixed opcode byte |
| req_operand | input | 8 | Value of the selected register |
| req_flags | input | 4 | Current flags {Z,N,H,C} |
| req_hl | input | ADDR_W | Pointer used for the memory operand |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, sampled at the end of the read cycle |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | 8 | Result byte, valid with done |
| res_flags | output | 4 | New flags {Z,N,H,C}, valid with done |
| res_wr_reg | output | 1 | Register write-back required, valid with done |
| res_reg_sel | output | 3 | Operand selector of the completed request |

## Verification
Byte patterns are chosen so that each one tells a specific pair of operations apart:
- 0x81 and 0x85 have both end bits set, so the circular rotates, the through-carry rotates and the arithmetic and logical shifts give different results.
- Operands that become zero, and a carry-in of 1 against one of 0, expose a wrong Z or a wrong carry source.
- Bit test, clear and set are tried on opposite bit positions with non-trivial input flags, so a flag that is wrongly altered shows up.

Memory forms are run with a decoy register operand, so that reading the register instead of the memory byte is caught. A second request is held during a memory sequence to exercise back-pressure.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    SH_RLC, SH_RRC, SH_RL, SH_RR, SH_SLA, SH_SRA, SH_SWAP, SH_SRL
  } shop_e;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} st_e;

  localparam int          BYTE_W  = 8;
  localparam logic [2:0]  SEL_MEM = 3'd6;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  typedef struct packed {
    grp_e       grp;
    logic [2:0] field;
    logic [2:0] sel;
    logic       is_mem;
  } dec_t;
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output dec_t              dec
);
  always_comb begin
    dec.grp    = grp_e'(opcode[7:6]);
    dec.field  = opcode[5:3];
    dec.sel    = opcode[2:0];
    dec.is_mem = (opcode[2:0] == SEL_MEM);
  end
endmodule

// File: rtl/cbu_alu.sv
module cbu_alu
  import cbu_pkg::*;
(
  input  grp_e              grp,
  input  logic [2:0]        field,
  input  logic [BYTE_W-1:0] din,
  input  flags_t            fin,
  output logic [BYTE_W-1:0] dout,
  output flags_t            fout
);
  logic [BYTE_W-1:0] mask;
  logic [BYTE_W-1:0] sh_res;
  logic              sh_c;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
    assign mask[i] = (field == 3'(i));
  end

  always_comb begin
    sh_res = din;
    sh_c   = 1'b0;
    unique case (shop_e'(field))
      SH_RLC:  begin sh_res = {din[6:0], din[7]};  sh_c = din[7]; end
      SH_RRC:  begin sh_res = {din[0], din[7:1]};  sh_c = din[0]; end
      SH_RL:   begin sh_res = {din[6:0], fin.c};   sh_c = din[7]; end
      SH_RR:   begin sh_res = {fin.c, din[7:1]};   sh_c = din[0]; end
      SH_SLA:  begin sh_res = {din[6:0], 1'b0};    sh_c = din[7]; end
      SH_SRA:  begin sh_res = {din[7], din[7:1]};  sh_c = din[0]; end
      SH_SWAP: begin sh_res = {din[3:0], din[7:4]}; sh_c = 1'b0;  end
      SH_SRL:  begin sh_res = {1'b0, din[7:1]};    sh_c = din[0]; end
      default: begin sh_res = din; sh_c = 1'b0; end
    endcase
  end

  always_comb begin
    dout = din;
    fout = fin;
    unique case (grp)
      GRP_SHIFT: begin
        dout = sh_res;
        fout = '{z: (sh_res == '0), n: 1'b0, h: 1'b0, c: sh_c};
      end
      GRP_TEST: begin
        dout = din;
        fout = '{z: ((din & mask) == '0), n: 1'b0, h: 1'b1, c: fin.c};
      end
      GRP_CLR: dout = din & ~mask;
      GRP_SET: dout = din | mask;
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/cbu_ctrl.sv
module cbu_ctrl
  import cbu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic start_mem,
  input  logic is_test,
  output logic ready,
  output logic rd,
  output logic wr,
  output logic fin
);
  st_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (accept) nxt = start_mem ? ST_READ : ST_DONE;
      ST_READ:  nxt = is_test ? ST_DONE : ST_WRITE;
      ST_WRITE: nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign ready = (state == ST_IDLE);
  assign rd    = (state == ST_READ);
  assign wr    = (state == ST_WRITE);
  assign fin   = (state == ST_DONE);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import cbu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [7:0]        req_operand,
  input  logic [3:0]        req_flags,
  input  logic [ADDR_W-1:0] req_hl,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [7:0]        res_data,
  output logic [3:0]        res_flags,
  output logic              res_wr_reg,
  output logic [2:0]        res_reg_sel
);
  logic              accept;
  logic [7:0]        op_q;
  logic [7:0]        byte_q;
  flags_t            flg_q;
  logic [ADDR_W-1:0] hl_q;
  dec_t              dq;
  logic [7:0]        alu_res;
  flags_t            alu_flg;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      byte_q <= '0;
      flg_q  <= '0;
      hl_q   <= '0;
    end else if (accept) begin
      op_q   <= req_opcode;
      byte_q <= req_operand;
      flg_q  <= flags_t'(req_flags);
      hl_q   <= req_hl;
    end else if (mem_rd) begin
      byte_q <= mem_rdata;
    end
  end

  cbu_decode u_dec (
    .opcode (op_q),
    .dec    (dq)
  );

  cbu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .start_mem (req_opcode[2:0] == SEL_MEM),
    .is_test   (dq.grp == GRP_TEST),
    .ready     (req_ready),
    .rd        (mem_rd),
    .wr        (mem_wr),
    .fin       (done)
  );

  cbu_alu u_alu (
    .grp   (dq.grp),
    .field (dq.field),
    .din   (byte_q),
    .fin   (flg_q),
    .dout  (alu_res),
    .fout  (alu_flg)
  );

  assign mem_addr    = hl_q;
  assign mem_wdata   = alu_res;
  assign res_data    = alu_res;
  assign res_flags   = alu_flg;
  assign res_reg_sel = dq.sel;
  assign res_wr_reg  = done && !dq.is_mem && (dq.grp != GRP_TEST);
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] req_opcode,
  input logic [3:0] req_flags,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       done,
  input logic [3:0] res_flags,
  input logic       res_wr_reg
);
  logic [7:0] cap_op;
  logic [3:0] cap_flg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_op  <= '0;
      cap_flg <= '0;
    end else if (req_valid && req_ready) begin
      cap_op  <= req_opcode;
      cap_flg <= req_flags;
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R8
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd)); // R8
  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (cap_op[7:6] != 2'b01)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || done) |-> !req_ready); // R10
  AST_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op[7]) |-> (res_flags == cap_flg)); // R6
  AST_TEST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op[7:6] == 2'b01) |->
      (res_flags[2:0] == {2'b01, cap_flg[0]} && !res_wr_reg)); // R5
  AST_SWAP_CLR_C: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op[7:3] == 5'b00110) |-> (res_flags[2:0] == 3'b000)); // R4
endmodule

bind bitop_unit bitop_unit_chk u_chk (.*);

// File: tb/tb_bitop_unit.sv
`timescale 1ns/1ps
module tb_bitop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_opcode = '0;
  logic [7:0]  req_operand = '0;
  logic [3:0]  req_flags = '0;
  logic [15:0] req_hl = '0;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic [7:0]  res_data;
  logic [3:0]  res_flags;
  logic        res_wr_reg;
  logic [2:0]  res_reg_sel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bitop_unit #(.ADDR_W(16)) dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Reference written from the requirement text
  function automatic void model(input logic [7:0] op, input logic [7:0] x,
                                input logic [3:0] f, output logic [7:0] r,
                                output logic [3:0] fo);
    int b;
    logic c;
    b = int'(op[5:3]);
    r = x;
    c = 1'b0;
    fo = f;
    case (op[7:6])
      2'b00: begin
        case (op[5:3])
          3'd0: begin r = (x << 1) | (x >> 7);           c = x[7]; end
          3'd1: begin r = (x >> 1) | (x << 7);           c = x[0]; end
          3'd2: begin r = (x << 1) | {7'd0, f[0]};       c = x[7]; end
          3'd3: begin r = (x >> 1) | {f[0], 7'd0};       c = x[0]; end
          3'd4: begin r = x << 1;                        c = x[7]; end
          3'd5: begin r = (x >> 1) | (x & 8'h80);        c = x[0]; end
          3'd6: begin r = (x << 4) | (x >> 4);           c = 1'b0; end
          default: begin r = x >> 1;                     c = x[0]; end
        endcase
        fo = {(r == 8'd0), 2'b00, c};
      end
      2'b01: fo = {~x[b], 1'b0, 1'b1, f[0]};
      2'b10: r = x & ~(8'd1 << b);
      default: r = x | (8'd1 << b);
    endcase
  endfunction

  task automatic run_op(input string req, input logic [7:0] op,
                        input logic [7:0] x, input logic [3:0] f,
                        input logic [15:0] hl, input logic [7:0] mbyte);
    logic [7:0] er;
    logic [3:0] ef;
    bit is_mem, is_test;
    int rd_c, wr_c, dn_c, exp_dn;
    logic [7:0] got_d, got_w;
    logic [3:0] got_f;
    logic got_wr_reg;
    logic [2:0] got_sel;
    logic [15:0] rd_a, wr_a;
    is_mem  = (op[2:0] == 3'd6);
    is_test = (op[7:6] == 2'b01);
    model(op, is_mem ? mbyte : x, f, er, ef);
    exp_dn = !is_mem ? 1 : (is_test ? 2 : 3);
    rd_c = 0; wr_c = 0; dn_c = 0;
    got_d = '0; got_w = '0; got_f = '0; got_wr_reg = 0; got_sel = '0;
    rd_a = '0; wr_a = '0;
    @(negedge clk);
    check(req_ready === 1'b1, "R10", "ready before request", {31'd0, req_ready}, 1);
    req_valid = 1'b1; req_opcode = op; req_operand = x;
    req_flags = f; req_hl = hl; mem_rdata = mbyte;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_operand = 8'h5A;
    for (int cyc = 1; cyc <= 5; cyc++) begin
      if (cyc > 1) @(negedge clk);
      if (mem_rd && rd_c == 0) begin rd_c = cyc; rd_a = mem_addr; end
      if (mem_wr && wr_c == 0) begin wr_c = cyc; wr_a = mem_addr; got_w = mem_wdata; end
      if (done && dn_c == 0) begin
        dn_c = cyc; got_d = res_data; got_f = res_flags;
        got_wr_reg = res_wr_reg; got_sel = res_reg_sel;
      end
    end
    check(dn_c == exp_dn, is_mem ? (is_test ? "R9" : "R8") : "R7",
          "done latency", dn_c, exp_dn);
    check(got_f == ef, req, "flags", got_f, ef);
    check(got_sel == op[2:0], "R1", "reg select", got_sel, op[2:0]);
    if (!is_mem) begin
      check(got_d == er, req, "register result", got_d, er);
      check(got_wr_reg == !is_test, is_test ? "R5" : "R7", "wr_reg",
            got_wr_reg, !is_test);
      check(rd_c == 0 && wr_c == 0, "R7", "no memory strobe", rd_c * 16 + wr_c, 0);
    end else begin
      check(rd_c == 1 && rd_a == hl, "R8", "read cycle/addr", {rd_c[15:0], rd_a}, {16'd1, hl});
      check(got_wr_reg == 1'b0, "R8", "no reg write", got_wr_reg, 0);
      if (is_test) begin
        check(wr_c == 0, "R9", "no write on test", wr_c, 0);
      end else begin
        check(wr_c == 2 && wr_a == hl, "R8", "write cycle/addr", {wr_c[15:0], wr_a}, {16'd2, hl});
        check(got_w == er, req, "written byte", got_w, er);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready === 1'b1 && done === 1'b0 && mem_rd === 1'b0 && mem_wr === 1'b0,
          "R11", "reset state", {req_ready, done, mem_rd, mem_wr}, 4'b1000);
  endtask

  task automatic t_rotates();
    run_op("R2", 8'h00, 8'h85, 4'h0, 16'h0, 8'h0);
    run_op("R2", 8'h09, 8'h01, 4'h0, 16'h0, 8'h0);
    run_op("R2", 8'h12, 8'h80, 4'h0, 16'h0, 8'h0);
    run_op("R2", 8'h1B, 8'h01, 4'h1, 16'h0, 8'h0);
    run_op("R2", 8'h17, 8'h81, 4'h1, 16'h0, 8'h0);
  endtask

  task automatic t_shifts();
    run_op("R3", 8'h24, 8'hC1, 4'h0, 16'h0, 8'h0);
    run_op("R3", 8'h2D, 8'h81, 4'h0, 16'h0, 8'h0);
    run_op("R3", 8'h3F, 8'h81, 4'h0, 16'h0, 8'h0);
    run_op("R3", 8'h28, 8'h01, 4'hE, 16'h0, 8'h0);
  endtask

  task automatic t_swap();
    run_op("R4", 8'h37, 8'hF0, 4'hF, 16'h0, 8'h0);
    run_op("R4", 8'h30, 8'h00, 4'h1, 16'h0, 8'h0);
  endtask

  task automatic t_bit_test();
    run_op("R5", 8'h7F, 8'h7F, 4'h1, 16'h0, 8'h0);
    run_op("R5", 8'h40, 8'h01, 4'h0, 16'h0, 8'h0);
  endtask

  task automatic t_clr_set();
    run_op("R6", 8'h99, 8'hFF, 4'hA, 16'h0, 8'h0);
    run_op("R6", 8'hFD, 8'h00, 4'h5, 16'h0, 8'h0);
    run_op("R6", 8'h87, 8'h01, 4'h3, 16'h0, 8'h0);
  endtask

  task automatic t_memory();
    run_op("R8", 8'hC6, 8'hAA, 4'h0, 16'h1234, 8'h10);
    run_op("R8", 8'h06, 8'hAA, 4'h6, 16'hBEEF, 8'h80);
    run_op("R9", 8'h66, 8'hAA, 4'h0, 16'h00F0, 8'h10);
    run_op("R9", 8'h46, 8'hFF, 4'h1, 16'h4321, 8'h00);
  endtask

  task automatic t_backpressure();
    logic [7:0] wd;
    @(negedge clk);
    req_valid = 1'b1; req_opcode = 8'hFE; req_operand = 8'h00;
    req_flags = 4'h0; req_hl = 16'h0042; mem_rdata = 8'h01;
    @(posedge clk);
    @(negedge clk);
    req_opcode = 8'h07; req_operand = 8'h81; req_flags = 4'h0;
    check(req_ready === 1'b0 && mem_rd === 1'b1, "R10", "busy in read", {req_ready, mem_rd}, 2'b01);
    @(negedge clk);
    wd = mem_wdata;
    check(mem_wr === 1'b1 && wd == 8'h81 && mem_addr == 16'h0042, "R10",
          "write during held request", {mem_wr, wd}, {1'b1, 8'h81});
    @(negedge clk);
    check(done === 1'b1 && req_ready === 1'b0, "R10", "done, not ready", {done, req_ready}, 2'b10);
    @(negedge clk);
    check(done === 1'b0 && req_ready === 1'b1, "R10", "idle after done", {done, req_ready}, 2'b01);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(done === 1'b1 && res_data == 8'h03 && res_reg_sel == 3'd7, "R10",
          "held request taken", {done, res_data}, {1'b1, 8'h03});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rotates();
    t_shifts();
    t_swap();
    t_bit_test();
    t_clr_set();
    t_memory();
    t_backpressure();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule